// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device holds low after it lost track of where it was in a transfer. A recovery is started with a one-cycle request. The sequencer then holds the neighbouring protocol engine in reset and lets both bus lines float high. It watches SDA and SCL through a synchroniser. While the bus is not free, it pulls SCL low for a fixed number of clock cycles and then lets it go. These pulses clock the confused target forward until it releases SDA.

The bus is re-examined before every pulse, and the sequence ends at the first check that finds both lines high. It also ends when a configurable number of pulses has been spent. In both cases the engine reset is lifted, a one-cycle completion strobe is raised, and a status bit reports whether the bus ended up free. SDA is only ever sampled and is never driven. SCL is driven low through an open-drain enable.

Top module: `i2c_bus_unjam`

## Requirements
- R1: Out of reset, `scl_oe_o`, `engine_rst_o`, `done_o` and `ok_o` are all low.
- R2: `engine_rst_o` is high in every cycle from the cycle after an accepted `start_i` up to, but not including, the cycle in which `done_o` is high. It is low in the `done_o` cycle.
- R3: The first bus check comes after SCL has been released for SETTLE_CYCLES cycles. If that check finds the bus free, no SCL pulse is issued and `ok_o` is 1.
- R4: The bus counts as free only when the synchronised SDA and SCL are both 1. A low on either line alone causes pulses.
- R5: Each SCL pulse holds `scl_oe_o` at 1 for exactly PULSE_CYCLES consecutive cycles. It is followed by at least SETTLE_CYCLES released cycles before the next check.
- R6: The bus is checked before every pulse, and the sequence stops at the first check that finds it free. A target that lets go after K pulses therefore sees exactly K pulses when K ≤ MAX_TRIES.
- R7: At most MAX_TRIES pulses are issued per recovery. If the bus is still not free at the check after the last pulse, `ok_o` is 0.
- R8: `done_o` is high for exactly one cycle per recovery. `ok_o` keeps its value from that cycle until the next accepted `start_i`.
- R9: `start_i` is accepted only when the sequencer is idle. While a recovery runs, further requests neither restart it nor add pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle recovery request |
| scl_i | input | 1 | SCL level read from the pad |
| sda_i | input | 1 | SDA level read from the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| engine_rst_o | output | 1 | Holds the protocol engine in reset during recovery |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | 1 when the bus was found free, valid from `done_o` |

## Verification
The bench builds the sequencer with PULSE_CYCLES=3, SETTLE_CYCLES=4 and MAX_TRIES=5. This keeps every recovery to a few dozen cycles. With these values, a target model that releases the line after any count from 0 to 7 pulses covers every outcome: an immediately free bus, early exit at each possible pulse, success on exactly the last allowed pulse, and budget exhaustion. The count is swept once with SDA held low and once with SCL held low. A further run issues extra requests during a recovery to show they are ignored.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;
   typedef enum logic [2:0] {
      UJ_IDLE   = 3'd0,
      UJ_SETTLE = 3'd1,
      UJ_CHECK  = 3'd2,
      UJ_LOW    = 3'd3,
      UJ_DONE   = 3'd4
   } uj_state_t;

   localparam int unsigned UJ_LINES = 2;
   localparam int unsigned UJ_SCL_IDX = 0;
   localparam int unsigned UJ_SDA_IDX = 1;
endpackage

// File: rtl/uj_line_sync.sv
module uj_line_sync #(
   parameter int unsigned LINES  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_i,
   output logic [LINES-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uj_line_sync: STAGES must be at least 2");
   end

   logic [LINES-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '1;
         end else if (s == 0) begin
            chain[s] <= raw_i;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/uj_down_timer.sv
module uj_down_timer #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   output logic             zero_o
);
   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/uj_try_counter.sv
module uj_try_counter #(
   parameter int unsigned LIMIT = 100,
   localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic spent_o
);
   logic [CW-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
      end else if (clear_i) begin
         used_q <= '0;
      end else if (step_i && !spent_o) begin
         used_q <= used_q + 1'b1;
      end
   end

   assign spent_o = (used_q >= CW'(LIMIT));
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
   import i2c_unjam_pkg::*;
#(
   parameter int unsigned PULSE_CYCLES  = 1000,
   parameter int unsigned SETTLE_CYCLES = 1000,
   parameter int unsigned MAX_TRIES     = 100,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_oe_o,
   output logic engine_rst_o,
   output logic done_o,
   output logic ok_o
);
   localparam int unsigned LONGEST = (PULSE_CYCLES > SETTLE_CYCLES) ? PULSE_CYCLES : SETTLE_CYCLES;
   localparam int unsigned TW      = $clog2(LONGEST + 1);
   localparam logic [TW-1:0] PULSE_LOAD  = TW'(PULSE_CYCLES - 1);
   localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYCLES - 1);

   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("i2c_bus_unjam: PULSE_CYCLES must be at least 1");
   end
   if (SETTLE_CYCLES < SYNC_STAGES + 1) begin : g_bad_settle
      $error("i2c_bus_unjam: SETTLE_CYCLES must cover the synchroniser latency");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("i2c_bus_unjam: MAX_TRIES must be at least 1");
   end

   uj_state_t state_q, state_d;
   logic [UJ_LINES-1:0] raw_lines, sync_lines;
   logic bus_free;
   logic tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic try_clear, try_step, try_spent;
   logic ok_q, ok_d;

   assign raw_lines[UJ_SCL_IDX] = scl_i;
   assign raw_lines[UJ_SDA_IDX] = sda_i;

   uj_line_sync #(
      .LINES  (UJ_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines),
      .sync_o (sync_lines)
   );

   assign bus_free = &sync_lines;

   uj_down_timer #(
      .WIDTH (TW)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   uj_try_counter #(
      .LIMIT (MAX_TRIES)
   ) u_tries (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (try_clear),
      .step_i  (try_step),
      .spent_o (try_spent)
   );

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = SETTLE_LOAD;
      try_clear = 1'b0;
      try_step  = 1'b0;
      ok_d      = ok_q;
      unique case (state_q)
         UJ_IDLE: begin
            if (start_i) begin
               state_d   = UJ_SETTLE;
               tmr_load  = 1'b1;
               try_clear = 1'b1;
               ok_d      = 1'b0;
            end
         end
         UJ_SETTLE: begin
            if (tmr_zero) state_d = UJ_CHECK;
         end
         UJ_CHECK: begin
            if (bus_free) begin
               state_d = UJ_DONE;
               ok_d    = 1'b1;
            end else if (try_spent) begin
               state_d = UJ_DONE;
               ok_d    = 1'b0;
            end else begin
               state_d  = UJ_LOW;
               tmr_load = 1'b1;
               tmr_val  = PULSE_LOAD;
               try_step = 1'b1;
            end
         end
         UJ_LOW: begin
            if (tmr_zero) begin
               state_d  = UJ_SETTLE;
               tmr_load = 1'b1;
            end
         end
         UJ_DONE: state_d = UJ_IDLE;
         default: state_d = UJ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= UJ_IDLE;
         ok_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         ok_q    <= ok_d;
      end
   end

   assign scl_oe_o     = (state_q == UJ_LOW);
   assign engine_rst_o = (state_q == UJ_SETTLE) || (state_q == UJ_CHECK) || (state_q == UJ_LOW);
   assign done_o       = (state_q == UJ_DONE);
   assign ok_o         = ok_q;
endmodule

// File: rtl/i2c_bus_unjam_chk.sv
module i2c_bus_unjam_chk #(
   parameter int unsigned PULSE_CYCLES = 1000,
   parameter int unsigned MAX_TRIES    = 100
) (
   input logic clk,
   input logic rst_n,
   input logic scl_oe_o,
   input logic engine_rst_o,
   input logic done_o,
   input logic ok_o
);
   localparam int unsigned HW = $clog2(PULSE_CYCLES + 2) + 1;
   localparam int unsigned PW = $clog2(MAX_TRIES + 2) + 1;

   logic [HW-1:0] hi_run;
   logic [PW-1:0] pulses;
   logic          oe_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run  <= '0;
         pulses  <= '0;
         oe_prev <= 1'b0;
      end else begin
         oe_prev <= scl_oe_o;
         hi_run  <= scl_oe_o ? hi_run + 1'b1 : '0;
         if (done_o) pulses <= '0;
         else if (scl_oe_o && !oe_prev) pulses <= pulses + 1'b1;
      end
   end

   a_r2_pulse_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe_o |-> engine_rst_o);

   a_r2_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(engine_rst_o) |-> done_o);

   a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_prev && !scl_oe_o) |-> (hi_run == HW'(PULSE_CYCLES)));

   a_r7_pulse_budget: assert property (@(posedge clk) disable iff (!rst_n)
      pulses <= PW'(MAX_TRIES));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_ok_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!engine_rst_o && !done_o && !$rose(engine_rst_o)) |=> (engine_rst_o || $stable(ok_o)));
endmodule

bind i2c_bus_unjam i2c_bus_unjam_chk #(
   .PULSE_CYCLES (PULSE_CYCLES),
   .MAX_TRIES    (MAX_TRIES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_oe_o     (scl_oe_o),
   .engine_rst_o (engine_rst_o),
   .done_o       (done_o),
   .ok_o         (ok_o)
);

// File: tb/i2c_bus_unjam_bench.sv
module i2c_bus_unjam_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PULSE  = 3;
   localparam int SETTLE = 4;
   localparam int TRIES  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic scl_i, sda_i;
   logic scl_oe_o, engine_rst_o, done_o, ok_o;

   logic hold_sda = 1'b0;
   logic hold_scl = 1'b0;
   int   release_after = 0;
   int   pulses = 0;
   int   hi_run = 0;
   int   width_bad = 0;
   int   gap_run = 100;
   int   gap_bad = 0;
   logic oe_prev = 1'b0;

   int checks = 0;
   int fails  = 0;

   assign scl_i = ~(scl_oe_o | hold_scl);
   assign sda_i = ~hold_sda;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_bus_unjam #(
      .PULSE_CYCLES  (PULSE),
      .SETTLE_CYCLES (SETTLE),
      .MAX_TRIES     (TRIES),
      .SYNC_STAGES   (2)
   ) u_i2c_bus_unjam (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .scl_i        (scl_i),
      .sda_i        (sda_i),
      .scl_oe_o     (scl_oe_o),
      .engine_rst_o (engine_rst_o),
      .done_o       (done_o),
      .ok_o         (ok_o)
   );

   // target model: lets go of its line once release_after pulses have ended
   always @(negedge clk) begin
      if (scl_oe_o) begin
         hi_run = hi_run + 1;
         if (!oe_prev && gap_run < SETTLE) gap_bad = gap_bad + 1;
         gap_run = 0;
      end else begin
         gap_run = gap_run + 1;
      end
      if (oe_prev && !scl_oe_o) begin
         pulses = pulses + 1;
         if (hi_run != PULSE) width_bad = width_bad + 1;
         hi_run = 0;
         if (pulses >= release_after) begin
            hold_sda = 1'b0;
            hold_scl = 1'b0;
         end
      end
      oe_prev = scl_oe_o;
   end

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   // one recovery: on_sda selects which line the target holds low
   task automatic recover(input int k, input bit on_sda, input bit extra_starts);
      int done_seen;
      int rst_bad;
      int cyc;
      int exp_p;
      release_after = k;
      pulses = 0;
      width_bad = 0;
      gap_bad = 0;
      gap_run = 100;
      hold_sda = on_sda && (k > 0);
      hold_scl = !on_sda && (k > 0);
      done_seen = 0;
      rst_bad = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 0;
      while (!done_o && cyc < 2000) begin
         if (!engine_rst_o) rst_bad++;
         if (extra_starts && (cyc % 7 == 3)) start_i = 1'b1;
         else start_i = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      exp_p = (k <= TRIES) ? k : TRIES;
      check("R2 engine reset held", rst_bad, 0);
      if (done_o) begin
         done_seen = 1;
         check("R2 reset low with done", int'(engine_rst_o), 0);
         check("R8 ok at done", int'(ok_o), (k <= TRIES) ? 1 : 0);
      end
      check("R8 done seen", done_seen, 1);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (done_o) done_seen++;
      end
      check("R8 single done", done_seen, 1);
      check("R8 ok held", int'(ok_o), (k <= TRIES) ? 1 : 0);
      if (k == 0) check("R3 free bus no pulse", pulses, 0);
      if (k <= TRIES) check(on_sda ? "R6 R4 pulses sda" : "R6 R4 pulses scl", pulses, exp_p);
      else check("R7 pulse budget", pulses, exp_p);
      check("R5 pulse width", width_bad, 0);
      check("R5 settle gap", gap_bad, 0);
      if (extra_starts) check("R9 extra starts ignored", pulses, exp_p);
      hold_sda = 1'b0;
      hold_scl = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 scl released", int'(scl_oe_o), 0);
      check("R1 engine reset", int'(engine_rst_o), 0);
      check("R1 done", int'(done_o), 0);
      check("R1 ok", int'(ok_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle after reset", int'(engine_rst_o), 0);
      for (int k = 0; k <= TRIES + 2; k++) recover(k, 1'b1, 1'b0);
      for (int k = 0; k <= TRIES + 2; k++) recover(k, 1'b0, 1'b0);
      recover(3, 1'b1, 1'b1);
      recover(TRIES + 1, 1'b0, 1'b1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule